// File: doc/BRIEF.md
# Configurable-Aspect Dual-Clock Block RAM

This block is a 4096-bit simple dual-port memory. It has one write port and one read port, and each port runs on its own clock. A 2-bit mode sets each port's data width on its own: 16, 8, 4 or 2 bits. Either port can therefore see the same storage at a different aspect ratio. In the narrow widths the data does not use the low-order bits of the 16-bit bus. It uses fixed lanes spread across the bus, so surrounding logic can wire a narrow port without shifting data.

All widths address one array of 256 rows of 16 bits. The low eight address bits pick the row. In a narrow mode, the next address bits pick an interleaved group of bits inside that row. Any address bits above those are ignored. Because of this layout, data written at one width reads back consistently at another.

Each port has a configuration bit that inverts its clock. A memory-enable input turns the whole block on or off, and a parameter sets the polarity of that input. An asynchronous active-low reset clears the registered read output.

Top module: `cfg_aspect_bram`

## Requirements
- R1: A write takes place on an active write-clock edge only when wrClkEn and wrEn are both 1 and the memory is enabled. A write with either strobe at 0 leaves the stored data unchanged.
- R2: During a write, a stored bit changes only when the wrMask bit on its bus lane is 0. A mask bit of 1 keeps the old value.
- R3: The registered rdData takes new data on an active read-clock edge only when rdClkEn and rdEn are both 1. Otherwise it keeps its previous value.
- R4: Mode codes for both ports: code 0 is 16 bits on lanes 15..0. Code 1 is 8 bits on the even lanes 0,2,...,14. Code 2 is 4 bits on lanes 1,5,9,13. Code 3 is 2 bits on lanes 3 and 11. Lanes a read mode does not use output 0.
- R5: The row is address bits [7:0]. The group is address bits [7+m:8] for mode m. Address bits above bit 7+m are ignored.
- R6: Narrow bit k (counted from the lowest lane) of group g in mode m maps to row bit k*2^m+g. Data written at one width reads back at any other width under this mapping.
- R7: wrMode and rdMode act independently of each other.
- R8: When wrClkInv or rdClkInv is 1, that port acts on the falling edge of its clock instead of the rising edge.
- R9: When memPower is not at the active level set by PWR_ACTIVE_HIGH, writes are ignored and rdData is 0. The stored content is kept.
- R10: While rstN is 0, rdData is 0, asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset of the read output register |
| memPower | input | 1 | Memory enable; active level set by PWR_ACTIVE_HIGH |
| wrClk | input | 1 | Write clock |
| wrClkInv | input | 1 | 1 = write on the falling edge |
| wrMode | input | 2 | Write width code (0:16, 1:8, 2:4, 3:2) |
| wrClkEn | input | 1 | Write clock enable |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 11 | Write address |
| wrData | input | 16 | Write data on the lanes of wrMode |
| wrMask | input | 16 | Per-lane write mask, 1 = keep |
| rdClk | input | 1 | Read clock |
| rdClkInv | input | 1 | 1 = read on the falling edge |
| rdMode | input | 2 | Read width code (0:16, 1:8, 2:4, 3:2) |
| rdClkEn | input | 1 | Read clock enable |
| rdEn | input | 1 | Read enable |
| rdAddr | input | 11 | Read address |
| rdData | output | 16 | Registered read data on the lanes of rdMode |

## Verification
The properties rely on a few conditions at the inputs:
- rdClkInv stays constant except while the memory is disabled or in reset, because toggling it produces a spurious clock edge.
- rdMode holds steady from a read edge until the output is observed.

The stimulus flips the clock-inversion bits only while rstN is low, with every enable at 0. It changes each port's inputs one nanosecond after that port's inactive edge. It keeps memPower steady around each read. The bench reads only rows that it has fully written, so no result depends on uninitialised storage.

// File: rtl/bram_pkg.sv
package bram_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 11;
  localparam int MODE_W    = 2;
  localparam int MAX_SHIFT = (1 << MODE_W) - 1;
  localparam int GRP_W     = MAX_SHIFT;
  localparam int ROW_W     = ADDR_W - MAX_SHIFT;
  localparam int ROWS      = 1 << ROW_W;
  localparam int LANE_W    = $clog2(DATA_W);

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [GRP_W-1:0]  grp_t;
  typedef logic [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic              wrFire;
    logic [ROW_W-1:0]  wrRow;
    logic [DATA_W-1:0] wrBitEn;
    logic [DATA_W-1:0] wrBits;
  } wrStrobe_t;

  typedef struct packed {
    logic              outOn;
    logic              rdFire;
    logic [ROW_W-1:0]  rdRow;
    mode_t             rdMode;
    grp_t              rdGrp;
  } rdStrobe_t;

  // first bus lane used by a mode
  function automatic lane_t laneOffset(mode_t m);
    lane_t off;
    off = '0;
    if (m != '0) off = lane_t'((1 << (m - 1'b1)) - 1);
    return off;
  endfunction

  // position of an index inside its interleave group
  function automatic lane_t subIndex(int idx, mode_t m);
    return lane_t'(idx & ((1 << m) - 1));
  endfunction

  function automatic logic [DATA_W-1:0] laneMask(mode_t m);
    logic [DATA_W-1:0] r;
    for (int l = 0; l < DATA_W; l++) r[l] = (subIndex(l, m) == laneOffset(m));
    return r;
  endfunction

  function automatic grp_t groupOf(logic [ADDR_W-1:0] a, mode_t m);
    grp_t gr;
    for (int b = 0; b < GRP_W; b++) gr[b] = a[ROW_W + b] && (b < int'(m));
    return gr;
  endfunction

  function automatic logic [DATA_W-1:0] wrEnables(mode_t m, grp_t gr, logic [DATA_W-1:0] mask);
    logic [DATA_W-1:0] r;
    lane_t sub, lane;
    for (int j = 0; j < DATA_W; j++) begin
      sub  = subIndex(j, m);
      lane = lane_t'(j) - sub + laneOffset(m);
      r[j] = (sub == lane_t'(gr)) && !mask[lane];
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] wrSpread(mode_t m, logic [DATA_W-1:0] data);
    logic [DATA_W-1:0] r;
    lane_t lane;
    for (int j = 0; j < DATA_W; j++) begin
      lane = lane_t'(j) - subIndex(j, m) + laneOffset(m);
      r[j] = data[lane];
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] rdFormat(mode_t m, grp_t gr, logic [DATA_W-1:0] row);
    logic [DATA_W-1:0] r;
    lane_t src;
    r = '0;
    for (int l = 0; l < DATA_W; l++) begin
      src = lane_t'(l) - laneOffset(m) + lane_t'(gr);
      if (subIndex(l, m) == laneOffset(m)) r[l] = row[src];
    end
    return r;
  endfunction
endpackage

// File: rtl/bram_ctrl.sv
module bram_ctrl
  import bram_pkg::*;
(
  input  logic              memOn,
  input  mode_t             wrMode,
  input  logic              wrClkEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] wrMask,
  input  mode_t             rdMode,
  input  logic              rdClkEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output wrStrobe_t         wrStb,
  output rdStrobe_t         rdStb
);
  grp_t wrGrp;

  always_comb begin
    wrGrp          = groupOf(wrAddr, wrMode);
    wrStb.wrFire   = memOn && wrClkEn && wrEn;
    wrStb.wrRow    = wrAddr[ROW_W-1:0];
    wrStb.wrBitEn  = wrEnables(wrMode, wrGrp, wrMask);
    wrStb.wrBits   = wrSpread(wrMode, wrData);
    rdStb.outOn    = memOn;
    rdStb.rdFire   = rdClkEn && rdEn;
    rdStb.rdRow    = rdAddr[ROW_W-1:0];
    rdStb.rdMode   = rdMode;
    rdStb.rdGrp    = groupOf(rdAddr, rdMode);
  end
endmodule

// File: rtl/bram_datapath.sv
module bram_datapath
  import bram_pkg::*;
(
  input  logic              wrClkEff,
  input  logic              rdClkEff,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  rdStrobe_t         rdStb,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] memArr [ROWS];
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge wrClkEff) begin
    if (wrStb.wrFire)
      memArr[wrStb.wrRow] <= (memArr[wrStb.wrRow] & ~wrStb.wrBitEn)
                           | (wrStb.wrBits & wrStb.wrBitEn);
  end

  always_ff @(posedge rdClkEff or negedge rstN) begin
    if (!rstN)
      rdReg <= '0;
    else if (!rdStb.outOn)
      rdReg <= '0;
    else if (rdStb.rdFire)
      rdReg <= rdFormat(rdStb.rdMode, rdStb.rdGrp, memArr[rdStb.rdRow]);
  end

  assign rdData = rdReg & {DATA_W{rdStb.outOn}};
endmodule

// File: rtl/cfg_aspect_bram.sv
module cfg_aspect_bram
  import bram_pkg::*;
#(
  parameter bit PWR_ACTIVE_HIGH = 1'b1
) (
  input  logic              rstN,
  input  logic              memPower,
  input  logic              wrClk,
  input  logic              wrClkInv,
  input  logic [1:0]        wrMode,
  input  logic              wrClkEn,
  input  logic              wrEn,
  input  logic [10:0]       wrAddr,
  input  logic [15:0]       wrData,
  input  logic [15:0]       wrMask,
  input  logic              rdClk,
  input  logic              rdClkInv,
  input  logic [1:0]        rdMode,
  input  logic              rdClkEn,
  input  logic              rdEn,
  input  logic [10:0]       rdAddr,
  output logic [15:0]       rdData
);
  logic      memOn;
  logic      wrClkEff;
  logic      rdClkEff;
  wrStrobe_t wrStb;
  rdStrobe_t rdStb;

  assign memOn    = (memPower == PWR_ACTIVE_HIGH);
  assign wrClkEff = wrClk ^ wrClkInv;
  assign rdClkEff = rdClk ^ rdClkInv;

  bram_ctrl i_ctrl (
    .memOn(memOn), .wrMode(wrMode), .wrClkEn(wrClkEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .wrMask(wrMask),
    .rdMode(rdMode), .rdClkEn(rdClkEn), .rdEn(rdEn), .rdAddr(rdAddr),
    .wrStb(wrStb), .rdStb(rdStb)
  );

  bram_datapath i_dp (
    .wrClkEff(wrClkEff), .rdClkEff(rdClkEff), .rstN(rstN),
    .wrStb(wrStb), .rdStb(rdStb), .rdData(rdData)
  );
endmodule

// File: rtl/bram_checker.sv
module bram_checker
  import bram_pkg::*;
#(
  parameter bit PWR_ACTIVE_HIGH = 1'b1
) (
  input logic        rstN,
  input logic        memPower,
  input logic        rdClk,
  input logic        rdClkInv,
  input logic [1:0]  rdMode,
  input logic        rdClkEn,
  input logic        rdEn,
  input logic [15:0] rdData
);
  logic memOn;
  logic rdClkEff;
  assign memOn    = (memPower == PWR_ACTIVE_HIGH);
  assign rdClkEff = rdClk ^ rdClkInv;

  AST_RD_HOLD: assert property (@(posedge rdClkEff) disable iff (!rstN)
    (memOn && !(rdClkEn && rdEn)) |=> (!memOn || $stable(rdData))); // R3

  AST_OFF_ZERO: assert property (@(posedge rdClkEff) disable iff (!rstN)
    !memOn |=> (memOn || rdData == '0)); // R9

  AST_IDLE_LANES: assert property (@(posedge rdClkEff) disable iff (!rstN)
    (memOn && rdClkEn && rdEn) |=> ((rdData & ~laneMask($past(rdMode))) == '0)); // R4

  AST_X2_WIDTH: assert property (@(posedge rdClkEff) disable iff (!rstN)
    (memOn && rdClkEn && rdEn && rdMode == 2'd3) |=> ($countones(rdData) <= 2)); // R4
endmodule

bind cfg_aspect_bram bram_checker #(.PWR_ACTIVE_HIGH(PWR_ACTIVE_HIGH)) i_chk (.*);

// File: tb/test_cfg_aspect_bram.sv
`timescale 1ns/100ps
module test_cfg_aspect_bram;
  logic        rstN = 1'b0, memPower = 1'b1;
  logic        wrClk = 1'b0, wrClkInv = 1'b0, wrClkEn = 1'b1, wrEn = 1'b0;
  logic [1:0]  wrMode = 2'd0, rdMode = 2'd0;
  logic [10:0] wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0, wrMask = '0;
  logic        rdClk = 1'b0, rdClkInv = 1'b0, rdClkEn = 1'b1, rdEn = 1'b0;
  logic [15:0] rdData;
  int total = 0, bad = 0;

  cfg_aspect_bram i_cfg_aspect_bram (.*);

  always #4 wrClk = ~wrClk;
  initial begin #1.5; forever #4 rdClk = ~rdClk; end

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrWaitActive();
    if (wrClkInv) @(negedge wrClk); else @(posedge wrClk);
  endtask
  task automatic wrWaitInactive();
    if (wrClkInv) @(posedge wrClk); else @(negedge wrClk);
  endtask
  task automatic rdWaitActive();
    if (rdClkInv) @(negedge rdClk); else @(posedge rdClk);
  endtask
  task automatic rdWaitInactive();
    if (rdClkInv) @(posedge rdClk); else @(negedge rdClk);
  endtask

  task automatic wrOp(logic [1:0] m, logic [10:0] a, logic [15:0] d, logic [15:0] k,
                      logic en = 1'b1, logic ce = 1'b1);
    wrWaitInactive(); #1;
    wrMode = m; wrAddr = a; wrData = d; wrMask = k; wrEn = en; wrClkEn = ce;
    wrWaitActive(); #1;
    wrEn = 1'b0; wrClkEn = 1'b1;
  endtask

  task automatic rdOp(logic [1:0] m, logic [10:0] a, output logic [15:0] q,
                      input logic en = 1'b1, input logic ce = 1'b1);
    rdWaitInactive(); #1;
    rdMode = m; rdAddr = a; rdEn = en; rdClkEn = ce;
    rdWaitActive(); #1;
    rdEn = 1'b0; rdClkEn = 1'b1;
    q = rdData;
  endtask

  task automatic testReset();
    #20; check("R10 reset output", rdData, 16'h0000);
    rstN = 1'b1; #10;
  endtask

  task automatic testWide();
    logic [15:0] q;
    wrOp(2'd0, 11'h005, 16'hA5C3, 16'h0000);
    rdOp(2'd0, 11'h005, q); check("R4 mode0 read", q, 16'hA5C3);
    rdOp(2'd0, 11'h705, q); check("R5 upper bits ignored mode0", q, 16'hA5C3);
    wrOp(2'd0, 11'h005, 16'hFFFF, 16'hFF00);
    rdOp(2'd0, 11'h005, q); check("R2 masked write", q, 16'hA5FF);
  endtask

  task automatic testNarrowRead();
    logic [15:0] q;
    rdOp(2'd1, 11'h005, q); check("R6 mode1 group0", q, 16'h0555);
    rdOp(2'd1, 11'h105, q); check("R6 mode1 group1", q, 16'h5055);
    rdOp(2'd1, 11'h605, q); check("R5 mode1 ignores bits 10:9", q, 16'h0555);
    rdOp(2'd2, 11'h205, q); check("R4 mode2 lanes group2", q, 16'h0222);
    rdOp(2'd3, 11'h505, q); check("R4 mode3 lanes group5", q, 16'h0808);
    rdOp(2'd3, 11'h405, q); check("R6 mode3 group4", q, 16'h0008);
  endtask

  task automatic testWriteGate();
    logic [15:0] q;
    wrOp(2'd0, 11'h005, 16'h0000, 16'h0000, 1'b1, 1'b0);
    rdOp(2'd0, 11'h005, q); check("R1 no write without clock enable", q, 16'hA5FF);
    wrOp(2'd0, 11'h005, 16'h0000, 16'h0000, 1'b0, 1'b1);
    rdOp(2'd0, 11'h005, q); check("R1 no write without write enable", q, 16'hA5FF);
  endtask

  task automatic testReadHold();
    logic [15:0] q;
    wrOp(2'd0, 11'h00A, 16'h0000, 16'h0000);
    rdOp(2'd0, 11'h005, q);
    rdOp(2'd0, 11'h00A, q, 1'b0, 1'b1); check("R3 hold with rdEn low", q, 16'hA5FF);
    rdOp(2'd0, 11'h00A, q, 1'b1, 1'b0); check("R3 hold with rdClkEn low", q, 16'hA5FF);
  endtask

  task automatic testPower();
    logic [15:0] q;
    memPower = 1'b0;
    rdOp(2'd0, 11'h005, q); check("R9 disabled output zero", q, 16'h0000);
    wrOp(2'd0, 11'h005, 16'h0000, 16'h0000);
    memPower = 1'b1;
    rdOp(2'd0, 11'h005, q); check("R9 disabled write ignored", q, 16'hA5FF);
  endtask

  task automatic testNarrowWrite();
    logic [15:0] q;
    wrOp(2'd3, 11'h60A, 16'hF7F7 | 16'h0808, 16'h0000);
    rdOp(2'd0, 11'h00A, q); check("R7 mode3 write, mode0 read", q, 16'h4040);
    wrOp(2'd2, 11'h10A, 16'h2002, 16'h0000);
    rdOp(2'd0, 11'h00A, q); check("R6 mode2 write group1", q, 16'h6042);
    wrOp(2'd1, 11'h00A, 16'h5555, 16'h0001);
    rdOp(2'd0, 11'h00A, q); check("R2 mode1 masked lane0", q, 16'h7556);
  endtask

  task automatic testInvert();
    logic [15:0] q;
    rstN = 1'b0; #5;
    wrClkInv = 1'b1; rdClkInv = 1'b1; #20;
    rstN = 1'b1; #5;
    wrOp(2'd0, 11'h014, 16'h1234, 16'h0000);
    rdOp(2'd0, 11'h014, q); check("R8 falling-edge write and read", q, 16'h1234);
  endtask

  task automatic testAsyncReset();
    rstN = 1'b0; #3;
    check("R10 async clear", rdData, 16'h0000);
    #10; rstN = 1'b1;
  endtask

  initial begin
    testReset();
    testWide();
    testNarrowRead();
    testWriteGate();
    testReadHold();
    testPower();
    testNarrowWrite();
    testInvert();
    testAsyncReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule